// File: doc/BRIEF.md
# Opcode Decoder and Branch Decision Unit

This block is the control section of a small 16-bit load/store processor whose instruction set packs every operation into a dense 4-bit opcode. There is no function field: the opcode alone selects the ALU operation, the source of the second operand, the destination register field, and the register-file and memory strobes. The block is purely combinational. It sits between the instruction register and the datapath muxes.

A separate gate-level branch unit takes the two branch flags from the decoder and the ALU Zero flag, and forms the PC-source select. Branch-if-equal is taken when Zero is high. Branch-if-not-equal is taken when Zero is low. Opcodes 12 to 15 are unassigned and are made harmless: nothing is written and no branch is taken.

Top module: `isa_ctrl_unit`

## Requirements
- R1: For opcodes 0 to 6 (register-format), the outputs are reg_dst=1, alu_src=0, reg_write=1, mem_to_reg=0, mem_read=0, mem_write=0, br_eq=0 and br_ne=0.
- R2: For opcodes 0 to 6, alu_op is 0010 (add), 0110 (sub), 0000 (and), 0001 (or), 1100 (nor), 1101 (nand) and 0111 (slt), in that opcode order.
- R3: For opcode 7 (add immediate), the outputs are reg_dst=0, alu_src=1, reg_write=1 and alu_op=0010. All memory strobes and branch flags are 0.
- R4: For opcode 8 (load), the outputs are reg_dst=0, alu_src=1, mem_to_reg=1, mem_read=1, reg_write=1, mem_write=0 and alu_op=0010. Both branch flags are 0.
- R5: For opcode 9 (store), the outputs are alu_src=1, mem_write=1 and alu_op=0010. All of reg_write, mem_read, mem_to_reg, reg_dst and both branch flags are 0.
- R6: For opcode 10, br_eq=1 and br_ne=0. For opcode 11, br_ne=1 and br_eq=0. Both use alu_op=0110 and alu_src=0, and both hold reg_write, mem_read, mem_write, mem_to_reg and reg_dst at 0.
- R7: pc_src = (br_eq AND zero) OR (br_ne AND NOT zero). The zero input has no effect on any other output.
- R8: For opcodes 12 to 15, every output is 0, including alu_op=0000 and pc_src, whatever the value of zero.
- R9: br_eq and br_ne are never both 1. mem_read and mem_write are never both 1. reg_write and mem_write are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 4 | Instruction opcode field |
| zero | input | 1 | ALU result-is-zero flag |
| reg_dst | output | 1 | 1 = write register from the rd field, 0 = from the rt field |
| alu_src | output | 1 | 1 = second ALU operand is the sign-extended immediate |
| mem_to_reg | output | 1 | 1 = register write data comes from memory |
| reg_write | output | 1 | Register-file write enable |
| mem_read | output | 1 | Data-memory read strobe |
| mem_write | output | 1 | Data-memory write strobe |
| alu_op | output | 4 | ALU operation code |
| br_eq | output | 1 | Branch-if-equal decoded |
| br_ne | output | 1 | Branch-if-not-equal decoded |
| pc_src | output | 1 | 1 = next PC is the branch target |

## Verification
Opcode decoding and the branch decision are resolved in the same cycle. The PC select depends on the decoded branch flag and also on the ALU Zero input, which arrives at the same time. The bench holds each opcode and drives both Zero values in consecutive cycles. It then follows with random opcode and Zero pairs. Every cycle it compares all outputs against a behavioural model. Two things are judged: pc_src must follow Zero only for the two branch opcodes, with opposite polarity for each, and every other output must stay the same when Zero flips.

// File: rtl/isa_ctrl_pkg.sv
// Shared widths, opcode values, ALU operation codes and the control bundle.
// Assumes a 4-bit opcode and a 4-bit ALU operation code.
package isa_ctrl_pkg;
    localparam int OPC_W   = 4;
    localparam int ALUOP_W = 4;
    localparam int N_RFMT  = 7;   // register-format opcodes 0..N_RFMT-1

    localparam logic [OPC_W-1:0] OPC_ADDI  = OPC_W'(7);
    localparam logic [OPC_W-1:0] OPC_LOAD  = OPC_W'(8);
    localparam logic [OPC_W-1:0] OPC_STORE = OPC_W'(9);
    localparam logic [OPC_W-1:0] OPC_BREQ  = OPC_W'(10);
    localparam logic [OPC_W-1:0] OPC_BRNE  = OPC_W'(11);

    localparam logic [ALUOP_W-1:0] ALU_AND  = 4'b0000;
    localparam logic [ALUOP_W-1:0] ALU_OR   = 4'b0001;
    localparam logic [ALUOP_W-1:0] ALU_ADD  = 4'b0010;
    localparam logic [ALUOP_W-1:0] ALU_SUB  = 4'b0110;
    localparam logic [ALUOP_W-1:0] ALU_SLT  = 4'b0111;
    localparam logic [ALUOP_W-1:0] ALU_NOR  = 4'b1100;
    localparam logic [ALUOP_W-1:0] ALU_NAND = 4'b1101;

    typedef struct packed {
        logic               reg_dst;
        logic               alu_src;
        logic               mem_to_reg;
        logic               reg_write;
        logic               mem_read;
        logic               mem_write;
        logic               br_eq;
        logic               br_ne;
        logic [ALUOP_W-1:0] alu_op;
    } ctl_s;
endpackage

// File: rtl/isa_rfmt_alu_map.sv
// Maps a register-format opcode (0..N_RFMT-1) onto its ALU operation code.
// Assumes the caller qualifies the result. Codes outside the range give AND.
module isa_rfmt_alu_map
    import isa_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode,
    output logic [ALUOP_W-1:0] r_alu_op
);
    // Purpose: table lookup from the dense opcode to the ALU operation code.
    always_comb begin
        case (opcode)
            OPC_W'(0): r_alu_op = ALU_ADD;
            OPC_W'(1): r_alu_op = ALU_SUB;
            OPC_W'(2): r_alu_op = ALU_AND;
            OPC_W'(3): r_alu_op = ALU_OR;
            OPC_W'(4): r_alu_op = ALU_NOR;
            OPC_W'(5): r_alu_op = ALU_NAND;
            OPC_W'(6): r_alu_op = ALU_SLT;
            default:   r_alu_op = ALU_AND;
        endcase
    end
endmodule

// File: rtl/isa_opdec.sv
// Main decoder: turns the opcode into the full control bundle.
// Assumes the R-format ALU code comes from isa_rfmt_alu_map. Unassigned
// opcodes give an all-zero bundle.
module isa_opdec
    import isa_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode,
    input  logic [ALUOP_W-1:0] r_alu_op,
    output ctl_s               ctl
);
    localparam logic [OPC_W-1:0] LAST_RFMT = OPC_W'(N_RFMT - 1);

    // Purpose: decode the opcode class into datapath selects and strobes.
    always_comb begin
        ctl = '0;
        if (opcode <= LAST_RFMT) begin
            ctl.reg_dst   = 1'b1;
            ctl.reg_write = 1'b1;
            ctl.alu_op    = r_alu_op;
        end else begin
            case (opcode)
                OPC_ADDI: begin
                    ctl.alu_src   = 1'b1;
                    ctl.reg_write = 1'b1;
                    ctl.alu_op    = ALU_ADD;
                end
                OPC_LOAD: begin
                    ctl.alu_src    = 1'b1;
                    ctl.mem_to_reg = 1'b1;
                    ctl.mem_read   = 1'b1;
                    ctl.reg_write  = 1'b1;
                    ctl.alu_op     = ALU_ADD;
                end
                OPC_STORE: begin
                    ctl.alu_src   = 1'b1;
                    ctl.mem_write = 1'b1;
                    ctl.alu_op    = ALU_ADD;
                end
                OPC_BREQ: begin
                    ctl.br_eq  = 1'b1;
                    ctl.alu_op = ALU_SUB;
                end
                OPC_BRNE: begin
                    ctl.br_ne  = 1'b1;
                    ctl.alu_op = ALU_SUB;
                end
                default: ctl = '0;
            endcase
        end
    end
endmodule

// File: rtl/isa_branch_unit.sv
// Gate-level branch decision: taken on equal with Zero high, or on
// not-equal with Zero low. Assumes at most one branch flag is set.
module isa_branch_unit (
    input  logic br_eq,
    input  logic br_ne,
    input  logic zero,
    output logic pc_src
);
    logic zero_n;
    logic take_eq;
    logic take_ne;

    not g_inv  (zero_n,  zero);
    and g_eq   (take_eq, br_eq, zero);
    and g_ne   (take_ne, br_ne, zero_n);
    or  g_sel  (pc_src,  take_eq, take_ne);
endmodule

// File: rtl/isa_ctrl_unit.sv
// Control unit top: opcode decoder, register-format ALU map and branch unit.
// Purely combinational. The assertions check the relations between the
// decoder and the branch unit.
module isa_ctrl_unit
    import isa_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode,
    input  logic               zero,
    output logic               reg_dst,
    output logic               alu_src,
    output logic               mem_to_reg,
    output logic               reg_write,
    output logic               mem_read,
    output logic               mem_write,
    output logic [ALUOP_W-1:0] alu_op,
    output logic               br_eq,
    output logic               br_ne,
    output logic               pc_src
);
    logic [ALUOP_W-1:0] r_alu_op;
    ctl_s               ctl;

    isa_rfmt_alu_map u_map (.opcode(opcode), .r_alu_op(r_alu_op));
    isa_opdec        u_dec (.opcode(opcode), .r_alu_op(r_alu_op), .ctl(ctl));
    isa_branch_unit  u_br  (.br_eq(ctl.br_eq), .br_ne(ctl.br_ne),
                            .zero(zero), .pc_src(pc_src));

    assign reg_dst    = ctl.reg_dst;
    assign alu_src    = ctl.alu_src;
    assign mem_to_reg = ctl.mem_to_reg;
    assign reg_write  = ctl.reg_write;
    assign mem_read   = ctl.mem_read;
    assign mem_write  = ctl.mem_write;
    assign alu_op     = ctl.alu_op;
    assign br_eq      = ctl.br_eq;
    assign br_ne      = ctl.br_ne;

    // Purpose: check the invariants across the decoder and the branch unit.
    always_comb begin
        // R9
        one_branch_flag_chk: assert (!(ctl.br_eq && ctl.br_ne));
        // R9
        mem_strobe_excl_chk: assert (!(ctl.mem_read && ctl.mem_write));
        // R5
        store_no_regwr_chk: assert (!(ctl.mem_write && ctl.reg_write));
        // R7
        taken_needs_flag_chk: assert (!pc_src || ctl.br_eq || ctl.br_ne);
        // R8
        undef_quiet_chk: assert (opcode < OPC_W'(12) || ctl == '0);
        // R4
        load_writes_chk: assert (!ctl.mem_read || (ctl.mem_to_reg && ctl.reg_write));
    end
endmodule

// File: tb/isa_ctrl_unit_tb.sv
// Bench: drives opcode/zero pairs every clock and compares all outputs
// against a behavioural model written from the requirements.
module isa_ctrl_unit_tb_top;
    logic       clk = 1'b0;
    logic [3:0] opcode = '0;
    logic       zero = 1'b0;
    logic       reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write;
    logic [3:0] alu_op;
    logic       br_eq, br_ne, pc_src;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    isa_ctrl_unit dut_i (
        .opcode(opcode), .zero(zero), .reg_dst(reg_dst), .alu_src(alu_src),
        .mem_to_reg(mem_to_reg), .reg_write(reg_write), .mem_read(mem_read),
        .mem_write(mem_write), .alu_op(alu_op), .br_eq(br_eq), .br_ne(br_ne),
        .pc_src(pc_src)
    );

    // control bits {reg_dst,alu_src,mem_to_reg,reg_write,mem_read,mem_write,br_eq,br_ne}
    function automatic logic [7:0] exp_bits(input int op);
        if (op <= 6)  return 8'b1001_0000;          // R1
        case (op)
            7:  return 8'b0101_0000;                 // R3
            8:  return 8'b0111_1000;                 // R4
            9:  return 8'b0100_0100;                 // R5
            10: return 8'b0000_0010;                 // R6
            11: return 8'b0000_0001;                 // R6
            default: return 8'b0000_0000;            // R8
        endcase
    endfunction

    function automatic logic [3:0] exp_alu(input int op);
        case (op)
            0: return 4'b0010;  1: return 4'b0110;  2: return 4'b0000;
            3: return 4'b0001;  4: return 4'b1100;  5: return 4'b1101;
            6: return 4'b0111;  7, 8, 9: return 4'b0010;
            10, 11: return 4'b0110;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string tag_of(input int op);
        if (op <= 6) return "R1";
        case (op)
            7: return "R3";  8: return "R4";  9: return "R5";
            10, 11: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic apply(input int op, input logic z);
        logic [7:0] got;
        logic       exp_pc;
        @(posedge clk);
        opcode = 4'(op);
        zero   = z;
        @(negedge clk);
        got = {reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, br_eq, br_ne};
        n_run++;
        if (got !== exp_bits(op)) begin
            n_fail++;
            $display("FAIL %s op=%0d zero=%0b ctl got=%b exp=%b", tag_of(op), op, z, got, exp_bits(op));
        end
        n_run++;
        if (alu_op !== exp_alu(op)) begin
            n_fail++;
            $display("FAIL %s op=%0d alu_op got=%b exp=%b", (op <= 6) ? "R2" : tag_of(op),
                     op, alu_op, exp_alu(op));
        end
        exp_pc = (op == 10 && z) || (op == 11 && !z);
        n_run++;
        if (pc_src !== exp_pc) begin
            n_fail++;
            $display("FAIL %s op=%0d zero=%0b pc_src got=%b exp=%b",
                     (op >= 12) ? "R8" : "R7", op, z, pc_src, exp_pc);
        end
        n_run++;
        if ((br_eq && br_ne) || (mem_read && mem_write) || (reg_write && mem_write)) begin
            n_fail++;
            $display("FAIL R9 op=%0d exclusive strobes got=%b exp=no overlap", op, got);
        end
    endtask

    // Purpose: watchdog that ends a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired got=%0d cycles exp=completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // Sweep every opcode with zero toggled back-to-back (R7 polarity).
        for (int pass = 0; pass < 2; pass++)
            for (int op = 0; op < 16; op++) begin
                apply(op, 1'b0);
                apply(op, 1'b1);
                apply(op, 1'b0);
            end
        // Random opcode/zero pairs.
        for (int k = 0; k < 300; k++)
            apply(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule